// File: doc/BRIEF.md
# Dual-Issue Pairing Decision Logic

This block sits at the issue stage of an in-order core that can start up to two instructions per cycle. Each cycle it is shown the two oldest pending instructions: an older one in slot 1 and a younger one in slot 2. Each comes with a valid bit and a 4-bit class code. The block also receives the older instruction's destination register and the younger instruction's source registers. From these it decides how many of the pair start this cycle: none, the older alone, or both.

Pairing is asymmetric. Some classes are allowed only in the younger position. Register-operand and shifted-operand ALU operations pair only with a younger immediate-type operation. A set of heavy classes always start alone. Three of them reserve the issue slots beyond their first cycle, and a small registered hold tracks that reservation. While a full hold is in force, `busy` is high and nothing new starts.

The instruction interface follows a valid/ready pattern in which `issue_cnt` acts as the ready.
- Slot 1 is accepted when `issue_cnt` is 1 or 2.
- Slot 2 is accepted only when `issue_cnt` is 2.
- The upstream queue pops exactly `issue_cnt` entries at the clock edge.
- Any entry that is not accepted must be presented again next cycle, stable and in order. An older instruction that issued alone lets the younger move up into slot 1.
- There is no downstream back-pressure input. Stalls come only from the pairing rules and the hold.

Top module: `dual_issue_pair`

## Requirements
- R1: `issue_cnt` is 0 whenever `o_valid` is 0, is 2 only when `y_valid` is 1, and never takes the value 3.
- R2: Class codes are: 0 direct branch, 1 call, 2 immediate ALU (including immediate moves and extends), 3 register ALU, 4 shifted-operand ALU, 5 multiply, 6 64-bit load/store, 7 core-to-FP transfer, 8 SIMD, 9 integer divide, 10 12-byte load/store, 11 16-byte load/store. Codes 12 to 15 are unknown and always issue alone.
- R3: A direct branch pairs as older or as younger, but two branch-type instructions (codes 0 and 1) never issue together.
- R4: A call issues alone or as the younger of a pair, never as the older of a pair.
- R5: An immediate ALU operation pairs in either position. An older code 0 or 2 pairs with a younger code 0, 1 or 2, subject to R3.
- R6: Register ALU (3) and shifted ALU (4) pair only as the older instruction, and only with a younger code 2. Neither pairs as the younger.
- R7: Codes 5 to 15 never pair in either position. When such an instruction is the valid older one and no hold is active, `issue_cnt` is 1.
- R8: A pair is refused (`issue_cnt` 1) when the older instruction has a valid destination equal to any valid source register of the younger instruction.
- R9: After an integer divide issues, `busy` is 1 and `issue_cnt` is 0 for the next DIV_CYCLES-1 cycles. Normal issue then resumes.
- R10: After a 16-byte load/store issues, `busy` is 1 and `issue_cnt` is 0 for exactly one cycle.
- R11: In the cycle after a 12-byte load/store issues, `busy` stays 0 and slot 1 alone is free of the old reservation. `issue_cnt` is 1 if the valid older instruction has code 0, 1 or 2, and 0 otherwise. The cycle after that issues normally.
- R12: Reset (`rst_n` low) clears any hold. After reset `busy` is 0 and issue follows the pairing rules at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| o_valid | input | 1 | Older instruction present |
| o_cls | input | 4 | Older instruction class code |
| o_dst | input | REG_W | Older instruction destination register |
| o_dst_vld | input | 1 | Older instruction writes a register |
| y_valid | input | 1 | Younger instruction present |
| y_cls | input | 4 | Younger instruction class code |
| y_srcs | input | N_SRC*REG_W | Younger source registers, source i at bits [i*REG_W +: REG_W] |
| y_srcs_vld | input | N_SRC | Per-source read enable of the younger instruction |
| issue_cnt | output | 2 | Number of instructions accepted this cycle (0, 1, 2) |
| busy | output | 1 | Full multi-cycle slot hold active |

## Verification
The bench builds the block with its defaults: REG_W 4, N_SRC 2 and DIV_CYCLES 5. With a 4-bit class code, all 256 older/younger class pairs can be swept. The sweep also covers every combination of the two valid bits and a dependency that is present or absent, and each result is compared against an arithmetic pairing rule in the bench. The short divide window of five cycles makes it cheap to walk every held cycle, along with the 16-byte hold and the 12-byte half-reserved tail. Directed cases cover each source port hitting the destination, dependency enables that are low, and a reset in the middle of a hold.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [3:0] {
    CLS_BR    = 4'd0,
    CLS_CALL  = 4'd1,
    CLS_AIMM  = 4'd2,
    CLS_AREG  = 4'd3,
    CLS_ASHF  = 4'd4,
    CLS_MUL   = 4'd5,
    CLS_MEM8  = 4'd6,
    CLS_XFER  = 4'd7,
    CLS_SIMD  = 4'd8,
    CLS_IDIV  = 4'd9,
    CLS_MEM12 = 4'd10,
    CLS_MEM16 = 4'd11
  } cls_e;

  // Branch-type: direct branch or call (R3)
  function automatic logic is_branchy(input logic [3:0] c);
    return (c == CLS_BR) || (c == CLS_CALL);
  endfunction

  // Classes allowed to occupy slot 2 (R5, R6)
  function automatic logic slot2_capable(input logic [3:0] c);
    return (c == CLS_BR) || (c == CLS_CALL) || (c == CLS_AIMM);
  endfunction

  // Older classes pairing with any slot-2-capable younger (R5)
  function automatic logic older_open(input logic [3:0] c);
    return (c == CLS_BR) || (c == CLS_AIMM);
  endfunction

  // Older classes pairing only with a younger immediate ALU (R6)
  function automatic logic older_imm_only(input logic [3:0] c);
    return (c == CLS_AREG) || (c == CLS_ASHF);
  endfunction

endpackage

// File: rtl/dip_class_rules.sv
module dip_class_rules
  import dual_issue_pkg::*;
(
  input  logic [3:0] o_cls,
  input  logic [3:0] y_cls,
  output logic       pair_ok,
  output logic       o_slot2_ok
);

  logic y_fits;
  logic o_fits;
  logic branch_clash;

  always_comb begin
    y_fits       = slot2_capable(y_cls);
    branch_clash = is_branchy(o_cls) && is_branchy(y_cls);
    o_fits       = older_open(o_cls) ||
                   (older_imm_only(o_cls) && (y_cls == CLS_AIMM));
    pair_ok      = y_fits && o_fits && !branch_clash;
    o_slot2_ok   = slot2_capable(o_cls);
  end

endmodule

// File: rtl/dip_dep_check.sv
module dip_dep_check #(
  parameter int REG_W = 4,
  parameter int N_SRC = 2
) (
  input  logic [REG_W-1:0]       o_dst,
  input  logic                   o_dst_vld,
  input  logic [N_SRC*REG_W-1:0] y_srcs,
  input  logic [N_SRC-1:0]       y_srcs_vld,
  output logic                   raw_hit
);

  logic [N_SRC-1:0] hit_vec;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit_vec[i] = y_srcs_vld[i] && o_dst_vld &&
                        (y_srcs[i*REG_W +: REG_W] == o_dst);
  end

  assign raw_hit = |hit_vec;

endmodule

// File: rtl/dip_hold_ctrl.sv
module dip_hold_ctrl
  import dual_issue_pkg::*;
#(
  parameter int DIV_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] start_cls,
  output logic       busy,
  output logic       half
);

  localparam int CW = (DIV_CYCLES > 2) ? $clog2(DIV_CYCLES) : 1;
  localparam logic [CW-1:0] DIV_HOLD = CW'(DIV_CYCLES - 1);

  logic [CW-1:0] hold_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_left <= '0;
      half      <= 1'b0;
    end else if (hold_left != '0) begin
      hold_left <= hold_left - CW'(1);
      half      <= 1'b0;
    end else if (start) begin
      case (start_cls)
        CLS_IDIV:  begin hold_left <= DIV_HOLD; half <= 1'b0; end
        CLS_MEM16: begin hold_left <= CW'(1);   half <= 1'b0; end
        CLS_MEM12: begin hold_left <= '0;       half <= 1'b1; end
        default:   begin hold_left <= '0;       half <= 1'b0; end
      endcase
    end else begin
      half <= 1'b0;
    end
  end

  assign busy = (hold_left != '0);

  AST_HALF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> !busy); // R11
  AST_HALF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    half |=> !half); // R11
  AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (hold_left < $past(hold_left))); // R9

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dual_issue_pkg::*;
#(
  parameter int REG_W      = 4,
  parameter int N_SRC      = 2,
  parameter int DIV_CYCLES = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   o_valid,
  input  logic [3:0]             o_cls,
  input  logic [REG_W-1:0]       o_dst,
  input  logic                   o_dst_vld,
  input  logic                   y_valid,
  input  logic [3:0]             y_cls,
  input  logic [N_SRC*REG_W-1:0] y_srcs,
  input  logic [N_SRC-1:0]       y_srcs_vld,
  output logic [1:0]             issue_cnt,
  output logic                   busy
);

  logic pair_ok;
  logic o_slot2_ok;
  logic raw_hit;
  logic half;
  logic older_go;

  dip_class_rules u_rules (
    .o_cls      (o_cls),
    .y_cls      (y_cls),
    .pair_ok    (pair_ok),
    .o_slot2_ok (o_slot2_ok)
  );

  dip_dep_check #(.REG_W(REG_W), .N_SRC(N_SRC)) u_dep (
    .o_dst      (o_dst),
    .o_dst_vld  (o_dst_vld),
    .y_srcs     (y_srcs),
    .y_srcs_vld (y_srcs_vld),
    .raw_hit    (raw_hit)
  );

  always_comb begin
    if (busy || !o_valid)
      issue_cnt = 2'd0;
    else if (half)
      issue_cnt = o_slot2_ok ? 2'd1 : 2'd0;
    else if (y_valid && pair_ok && !raw_hit)
      issue_cnt = 2'd2;
    else
      issue_cnt = 2'd1;
  end

  assign older_go = (issue_cnt != 2'd0);

  dip_hold_ctrl #(.DIV_CYCLES(DIV_CYCLES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (older_go),
    .start_cls (o_cls),
    .busy      (busy),
    .half      (half)
  );

  AST_NEVER_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt != 2'd3); // R1
  AST_SLOT1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt != 2'd0) |-> o_valid); // R1
  AST_SLOT2_NEEDS_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> y_valid); // R1
  AST_NO_TWO_BRANCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> !(is_branchy(o_cls) && is_branchy(y_cls))); // R3
  AST_CALL_NOT_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> (o_cls != CLS_CALL)); // R4
  AST_HEAVY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> (o_cls < 4'd5 && y_cls < 4'd3)); // R7
  AST_RAW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> !raw_hit); // R8
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (issue_cnt == 2'd0)); // R9
  AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (older_go && o_cls == CLS_IDIV) |=> busy); // R9
  AST_MEM16_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (older_go && o_cls == CLS_MEM16) |=> busy); // R10
  AST_MEM12_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (older_go && o_cls == CLS_MEM12) |=> (!busy && issue_cnt != 2'd2)); // R11

endmodule

// File: tb/dual_issue_pair_test.sv
module dual_issue_pair_test;

  localparam int REG_W = 4;
  localparam int N_SRC = 2;
  localparam int DIVC  = 5;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   o_valid = 1'b0;
  logic [3:0]             o_cls = '0;
  logic [REG_W-1:0]       o_dst = '0;
  logic                   o_dst_vld = 1'b0;
  logic                   y_valid = 1'b0;
  logic [3:0]             y_cls = '0;
  logic [N_SRC*REG_W-1:0] y_srcs = '0;
  logic [N_SRC-1:0]       y_srcs_vld = '0;
  logic [1:0]             issue_cnt;
  logic                   busy;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dual_issue_pair #(.REG_W(REG_W), .N_SRC(N_SRC), .DIV_CYCLES(DIVC)) uut (
    .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_cls(o_cls),
    .o_dst(o_dst), .o_dst_vld(o_dst_vld), .y_valid(y_valid), .y_cls(y_cls),
    .y_srcs(y_srcs), .y_srcs_vld(y_srcs_vld), .issue_cnt(issue_cnt), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (o=%0d y=%0d ov=%0b yv=%0b)",
               req, act, exp, o_cls, y_cls, o_valid, y_valid);
    end
  endtask

  // Reference pairing rule written from the requirement list
  function automatic int ref_issue(input int ov, input int yv, input int oc,
                                   input int yc, input int dep);
    bit y_ok, o_ok;
    if (ov == 0) return 0;
    if (yv == 0 || dep != 0) return 1;
    y_ok = (yc <= 2);
    o_ok = ((oc == 0 || oc == 2) && !(oc == 0 && yc <= 1)) ||
           ((oc == 3 || oc == 4) && yc == 2);
    return (y_ok && o_ok) ? 2 : 1;
  endfunction

  task automatic drive(input bit ov, input int oc, input bit yv, input int yc);
    @(negedge clk);
    o_valid = ov; o_cls = 4'(oc); y_valid = yv; y_cls = 4'(yc);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 2, 1'b0, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    o_dst = 4'd5; o_dst_vld = 1'b1;
    repeat (3) @(posedge clk);
    // R12: held in reset, no hold
    @(negedge clk);
    check("R12 busy in reset", busy, 0);
    rst_n = 1'b1;
    drive(1'b1, 2, 1'b1, 2);
    y_srcs = {4'd7, 4'd6}; y_srcs_vld = 2'b11; #1;
    check("R12 pairs right after reset", issue_cnt, 2);

    // R1..R8: full sweep of class pairs, valids and dependency
    for (int oc = 0; oc < 16; oc++)
      for (int yc = 0; yc < 16; yc++)
        for (int v = 0; v < 4; v++)
          for (int dep = 0; dep < 2; dep++) begin
            int e;
            @(negedge clk);
            o_valid = v[0]; y_valid = v[1];
            o_cls = 4'(oc); y_cls = 4'(yc);
            y_srcs = dep ? {4'd7, 4'd5} : {4'd7, 4'd6};
            y_srcs_vld = 2'b11;
            #1;
            e = ref_issue(v[0], v[1], oc, yc, dep);
            check("R1-sweep R2 R3 R4 R5 R6 R7 R8 issue", issue_cnt, e);
            if (e != 0 && (oc == 9 || oc == 10 || oc == 11)) idle(DIVC + 1);
          end

    // R8: second source hits, disabled source, no destination
    y_srcs = {4'd5, 4'd6}; y_srcs_vld = 2'b10;
    drive(1'b1, 2, 1'b1, 2);
    check("R8 src b hit refuses pair", issue_cnt, 1);
    y_srcs_vld = 2'b01; #1;
    check("R8 disabled source ignored", issue_cnt, 2);
    y_srcs_vld = 2'b11; o_dst_vld = 1'b0; #1;
    check("R8 no destination no hazard", issue_cnt, 2);
    o_dst_vld = 1'b1; y_srcs = {4'd7, 4'd6};

    // R9: divide hold
    drive(1'b1, 9, 1'b1, 2);
    check("R9 divide issues alone", issue_cnt, 1);
    for (int k = 0; k < DIVC - 1; k++) begin
      drive(1'b1, 2, 1'b1, 2);
      check("R9 busy during divide", busy, 1);
      check("R9 no issue during divide", issue_cnt, 0);
    end
    drive(1'b1, 2, 1'b1, 2);
    check("R9 busy released", busy, 0);
    check("R9 pair after divide", issue_cnt, 2);

    // R10: 16-byte hold
    drive(1'b1, 11, 1'b1, 2);
    check("R10 wide mem alone", issue_cnt, 1);
    drive(1'b1, 2, 1'b1, 2);
    check("R10 busy one cycle", busy, 1);
    check("R10 no issue in hold", issue_cnt, 0);
    drive(1'b1, 2, 1'b1, 2);
    check("R10 released", issue_cnt, 2);

    // R11: 12-byte tail
    drive(1'b1, 10, 1'b1, 2);
    check("R11 12-byte alone", issue_cnt, 1);
    drive(1'b1, 3, 1'b1, 2);
    check("R11 tail not busy", busy, 0);
    check("R11 reg ALU blocked in tail", issue_cnt, 0);
    drive(1'b1, 3, 1'b1, 2);
    check("R11 normal after tail", issue_cnt, 2);
    drive(1'b1, 10, 1'b1, 2);
    drive(1'b1, 2, 1'b1, 2);
    check("R11 imm ALU single in tail", issue_cnt, 1);
    drive(1'b1, 10, 1'b0, 2);
    drive(1'b1, 1, 1'b1, 2);
    check("R11 call single in tail", issue_cnt, 1);

    // R12: reset during a divide hold
    drive(1'b1, 9, 1'b0, 2);
    drive(1'b1, 2, 1'b1, 2);
    check("R12 hold before reset", busy, 1);
    rst_n = 1'b0; #1;
    check("R12 reset clears hold", busy, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R12 issue resumes", issue_cnt, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule